// File: doc/BRIEF.md
# Pipeline Scoreboard Interlock Unit

This unit is the hazard-detection control for an in-order pipeline with four stages: fetch, decode, execute and writeback. Each cycle it looks at the instruction in decode and decides whether that instruction can issue into execute. It also decides, for each source operand, whether the value comes from the register file or from one of two forwarding paths. When neither source can supply a value, it stalls decode and fetch and sends a bubble into execute. The unit does not contain the datapath, the caches or any branch prediction.

The unit keeps one valid bit for each architectural register. Issuing a writer clears that register's bit, and the writer's writeback sets it again. The unit also keeps a valid bit on each of the two forwarding paths. The execute-output path is valid for a non-load producer. A load's result cannot be consumed until it reaches writeback. Only read-after-write dependencies can stall. When a conditional branch issues, fetch is held until the branch is resolved. While the branch is pending, a taken resolution raises a flush.

Top module: `scoreboard_interlock`

## Requirements
- R1: After reset every register reads as valid, no writer is in flight and no branch is pending. With no instruction in decode, `stall`, `issue`, `fetchHold` and `flush` are all low and both operand selects are 0.
- R2: A source whose register is invalid, and whose youngest in-flight writer has no consumable path, causes a stall. In that cycle `stall`=1, `issue`=0, `fetchHold`=1 and the operand select reads 0. The same instruction issues in a later cycle.
- R3: A write-after-write or write-after-read relationship with an in-flight instruction never stalls decode.
- R4: A source produced by the non-load instruction now in execute is forwarded without a stall, with select code 1 (execute path).
- R5: A source produced by the instruction now in writeback is forwarded with select code 2 (writeback path). A consumer directly behind a load stalls exactly one cycle and then takes code 2.
- R6: Register 0 never causes a stall, always selects code 0 (register file), and is never made invalid by a writer that names it.
- R7: When an issuing writer and a completing writeback name the same register in one cycle, the register stays invalid.
- R8: A writeback does not revalidate its register while a younger writer of the same register sits in execute.
- R9: Fetch is held in the cycle a branch issues and in every following cycle up to and including the cycle in which `brResolve` is high. A branch in decode therefore produces two repeated fetch slots when it resolves in execute.
- R10: `flush` is high only when a branch is pending and `brResolve` and `brTaken` are both high. A resolution with no branch pending has no effect.
- R11: When both the execute and writeback stages write a source register, the execute path (the younger writer) is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode holds an instruction |
| decSrcA | input | 5 | First source register (0 when unused) |
| decSrcB | input | 5 | Second source register (0 when unused) |
| decDst | input | 5 | Destination register |
| decWrites | input | 1 | Instruction writes `decDst` |
| decLoad | input | 1 | Instruction is a load |
| decBranch | input | 1 | Instruction is a conditional branch |
| brResolve | input | 1 | Pending branch resolves this cycle |
| brTaken | input | 1 | Resolved branch redirects fetch |
| issue | output | 1 | Decode instruction enters execute this cycle |
| stall | output | 1 | Decode holds, bubble into execute |
| fetchHold | output | 1 | Fetch repeats its slot |
| flush | output | 1 | Discard fetched work and redirect |
| bypSelA | output | 2 | Source A select: 0 register file, 1 execute path, 2 writeback path |
| bypSelB | output | 2 | Source B select, same coding |

## Verification
Register valid bits and path valid bits are hidden state, so they are observed through the operand selects and the stall on later consumers. A bit that is wrongly set shows up as select code 0 where 1 or 2 is expected, and this is visible one or two cycles after the writeback in question. A bit that is wrongly left clear, or a lost path valid bit, shows up as an unexpected stall on the next reader. The sequences place readers directly after the write-after-write case, the same-cycle set and clear case, and load writebacks, so that each fault appears within two cycles.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    SEL_RF = 2'd0,
    SEL_EX = 2'd1,
    SEL_WB = 2'd2
  } opSel_e;

  // Strobes the control sends to the tracking datapath each cycle.
  typedef struct packed {
    logic issue;        // decode instruction advances into execute
    logic allocWr;      // it writes a non-zero register
    logic allocLoad;    // it is a load
    logic allocBranch;  // it is a conditional branch
  } sbStrobe_t;

endpackage

// File: rtl/sb_operand.sv
module sb_operand
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic [AW-1:0]       src,
  input  logic [NUM_REGS-1:0] regValid,
  input  logic                exWriter,
  input  logic [AW-1:0]       exDst,
  input  logic                exPathValid,
  input  logic                wbWriter,
  input  logic [AW-1:0]       wbDst,
  input  logic                wbPathValid,
  output opSel_e              sel,
  output logic                hazard
);

  // The youngest in-flight writer decides the source.
  always_comb begin
    sel    = SEL_RF;
    hazard = 1'b0;
    if (src != '0 && !regValid[src]) begin
      if (exWriter && exDst == src) begin
        if (exPathValid) sel = SEL_EX;
        else             hazard = 1'b1;
      end else if (wbWriter && wbDst == src) begin
        if (wbPathValid) sel = SEL_WB;
        else             hazard = 1'b1;
      end else begin
        hazard = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int NUM_SRC  = 2,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                decValid,
  input  logic [AW-1:0]       decSrc [NUM_SRC],
  input  logic [AW-1:0]       decDst,
  input  logic                decWrites,
  input  logic                decLoad,
  input  logic                decBranch,
  input  logic [NUM_REGS-1:0] regValid,
  input  logic                exWriter,
  input  logic [AW-1:0]       exDst,
  input  logic                exPathValid,
  input  logic                wbWriter,
  input  logic [AW-1:0]       wbDst,
  input  logic                wbPathValid,
  input  logic                brWait,
  input  logic                brResolve,
  input  logic                brTaken,
  output sbStrobe_t           strobe,
  output logic                stall,
  output logic                fetchHold,
  output logic                flush,
  output opSel_e              opSel [NUM_SRC]
);

  logic [NUM_SRC-1:0] hazard;

  for (genvar k = 0; k < NUM_SRC; k++) begin : gOperand
    sb_operand #(.NUM_REGS(NUM_REGS)) uOperand (
      .src         (decSrc[k]),
      .regValid    (regValid),
      .exWriter    (exWriter),
      .exDst       (exDst),
      .exPathValid (exPathValid),
      .wbWriter    (wbWriter),
      .wbDst       (wbDst),
      .wbPathValid (wbPathValid),
      .sel         (opSel[k]),
      .hazard      (hazard[k])
    );
  end

  always_comb begin
    stall              = decValid && (|hazard);
    strobe.issue       = decValid && !stall;
    strobe.allocWr     = decWrites && (decDst != '0);
    strobe.allocLoad   = decLoad;
    strobe.allocBranch = decBranch;
    fetchHold          = stall || (strobe.issue && decBranch) || brWait;
    flush              = brWait && brResolve && brTaken;
  end

endmodule

// File: rtl/sb_track.sv
module sb_track
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  sbStrobe_t           strobe,
  input  logic [AW-1:0]       decDst,
  input  logic                brResolve,
  output logic [NUM_REGS-1:0] regValid,
  output logic                exWriter,
  output logic [AW-1:0]       exDst,
  output logic                exPathValid,
  output logic                wbWriter,
  output logic [AW-1:0]       wbDst,
  output logic                wbPathValid,
  output logic                brWait
);

  logic allocNow;
  assign allocNow = strobe.issue && strobe.allocWr;

  assign regValid[0] = 1'b1;

  for (genvar gi = 1; gi < NUM_REGS; gi++) begin : gReg
    logic clrHit, setHit;
    assign clrHit = allocNow && (decDst == AW'(gi));
    // A younger writer in execute keeps the register invalid.
    assign setHit = wbWriter && (wbDst == AW'(gi)) &&
                    !(exWriter && exDst == AW'(gi));
    always_ff @(posedge clk) begin
      if (!rstN)       regValid[gi] <= 1'b1;
      else if (clrHit) regValid[gi] <= 1'b0;
      else if (setHit) regValid[gi] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exWriter    <= 1'b0;
      exDst       <= '0;
      exPathValid <= 1'b0;
      wbWriter    <= 1'b0;
      wbDst       <= '0;
      wbPathValid <= 1'b0;
      brWait      <= 1'b0;
    end else begin
      exWriter    <= allocNow;
      exDst       <= decDst;
      exPathValid <= allocNow && !strobe.allocLoad;
      wbWriter    <= exWriter;
      wbDst       <= exDst;
      wbPathValid <= exWriter;
      if (strobe.issue && strobe.allocBranch) brWait <= 1'b1;
      else if (brResolve)                     brWait <= 1'b0;
    end
  end

endmodule

// File: rtl/scoreboard_interlock.sv
module scoreboard_interlock
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int AW = $clog2(NUM_REGS),
  localparam int NUM_SRC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          decValid,
  input  logic [AW-1:0] decSrcA,
  input  logic [AW-1:0] decSrcB,
  input  logic [AW-1:0] decDst,
  input  logic          decWrites,
  input  logic          decLoad,
  input  logic          decBranch,
  input  logic          brResolve,
  input  logic          brTaken,
  output logic          issue,
  output logic          stall,
  output logic          fetchHold,
  output logic          flush,
  output logic [1:0]    bypSelA,
  output logic [1:0]    bypSelB
);

  sbStrobe_t           strobe;
  logic [NUM_REGS-1:0] regValid;
  logic                exWriter, exPathValid, wbWriter, wbPathValid, brWait;
  logic [AW-1:0]       exDst, wbDst;
  logic [AW-1:0]       srcArr [NUM_SRC];
  opSel_e              selArr [NUM_SRC];

  assign srcArr[0] = decSrcA;
  assign srcArr[1] = decSrcB;

  sb_ctrl #(.NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC)) uCtrl (
    .decValid    (decValid),
    .decSrc      (srcArr),
    .decDst      (decDst),
    .decWrites   (decWrites),
    .decLoad     (decLoad),
    .decBranch   (decBranch),
    .regValid    (regValid),
    .exWriter    (exWriter),
    .exDst       (exDst),
    .exPathValid (exPathValid),
    .wbWriter    (wbWriter),
    .wbDst       (wbDst),
    .wbPathValid (wbPathValid),
    .brWait      (brWait),
    .brResolve   (brResolve),
    .brTaken     (brTaken),
    .strobe      (strobe),
    .stall       (stall),
    .fetchHold   (fetchHold),
    .flush       (flush),
    .opSel       (selArr)
  );

  sb_track #(.NUM_REGS(NUM_REGS)) uTrack (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .decDst      (decDst),
    .brResolve   (brResolve),
    .regValid    (regValid),
    .exWriter    (exWriter),
    .exDst       (exDst),
    .exPathValid (exPathValid),
    .wbWriter    (wbWriter),
    .wbDst       (wbDst),
    .wbPathValid (wbPathValid),
    .brWait      (brWait)
  );

  assign issue   = strobe.issue;
  assign bypSelA = selArr[0];
  assign bypSelB = selArr[1];

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          decValid,
  input logic [AW-1:0] decSrcA,
  input logic [AW-1:0] decSrcB,
  input logic [AW-1:0] decDst,
  input logic          decLoad,
  input logic          decBranch,
  input logic          brResolve,
  input logic          issue,
  input logic          stall,
  input logic          fetchHold,
  input logic          flush,
  input logic [1:0]    bypSelA,
  input logic [1:0]    bypSelB
);

  AST_STALL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (!issue && fetchHold)); // R2

  AST_ZERO_SRC_FROM_RF: assert property (@(posedge clk) disable iff (!rstN)
    (decSrcA == '0) |-> (bypSelA == 2'd0 && (decSrcB != '0 || bypSelB == 2'd0))); // R6

  AST_LOAD_USE_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (issue && decLoad && decDst != '0) |=>
      !(decValid && decSrcA == $past(decDst) && issue)); // R5

  AST_BRANCH_HOLDS_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (issue && decBranch && !brResolve) |=> fetchHold); // R9

  AST_FLUSH_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (fetchHold && brResolve)); // R10

  AST_SEL_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (bypSelA != 2'd3 && bypSelB != 2'd3)); // R4

endmodule

bind scoreboard_interlock sb_checker #(.AW(AW)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .decValid  (decValid),
  .decSrcA   (decSrcA),
  .decSrcB   (decSrcB),
  .decDst    (decDst),
  .decLoad   (decLoad),
  .decBranch (decBranch),
  .brResolve (brResolve),
  .issue     (issue),
  .stall     (stall),
  .fetchHold (fetchHold),
  .flush     (flush),
  .bypSelA   (bypSelA),
  .bypSelB   (bypSelB)
);

// File: tb/sim_scoreboard_interlock.sv
module sim_scoreboard_interlock;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       decValid = 1'b0;
  logic [4:0] decSrcA = '0, decSrcB = '0, decDst = '0;
  logic       decWrites = 1'b0, decLoad = 1'b0, decBranch = 1'b0;
  logic       brResolve = 1'b0, brTaken = 1'b0;
  logic       issue, stall, fetchHold, flush;
  logic [1:0] bypSelA, bypSelB;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic       iss, stl, fh, fl;
    logic [1:0] sa, sb;
    string      tag;
  } exp_t;

  exp_t expQ[$];

  always #5 clk = ~clk;

  scoreboard_interlock u0 (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decSrcA(decSrcA),
    .decSrcB(decSrcB), .decDst(decDst), .decWrites(decWrites),
    .decLoad(decLoad), .decBranch(decBranch), .brResolve(brResolve),
    .brTaken(brTaken), .issue(issue), .stall(stall), .fetchHold(fetchHold),
    .flush(flush), .bypSelA(bypSelA), .bypSelB(bypSelB)
  );

  // Driver: one decode cycle plus the outputs the requirements predict.
  task automatic cyc(input logic v, input logic [4:0] a, input logic [4:0] b,
                     input logic [4:0] d, input logic w, input logic ld,
                     input logic br, input logic res, input logic tk,
                     input logic ei, input logic es, input logic eh,
                     input logic ef, input logic [1:0] esa,
                     input logic [1:0] esb, input string tag);
    exp_t e;
    @(negedge clk);
    decValid = v; decSrcA = a; decSrcB = b; decDst = d; decWrites = w;
    decLoad = ld; decBranch = br; brResolve = res; brTaken = tk;
    e.iss = ei; e.stl = es; e.fh = eh; e.fl = ef; e.sa = esa; e.sb = esb;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compares the outputs a little after the inputs settle.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (issue !== e.iss || stall !== e.stl || fetchHold !== e.fh ||
            flush !== e.fl || bypSelA !== e.sa || bypSelB !== e.sb) begin
          failures++;
          $display("FAIL %s: got iss=%b stl=%b fh=%b fl=%b sa=%0d sb=%0d exp iss=%b stl=%b fh=%b fl=%b sa=%0d sb=%0d",
                   e.tag, issue, stall, fetchHold, flush, bypSelA, bypSelB,
                   e.iss, e.stl, e.fh, e.fl, e.sa, e.sb);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    //   v a  b  d  w ld br rs tk   iss stl fh fl sa sb
    cyc(0, 0, 0, 0, 0,0,0,0,0,     0,0,0,0,0,0, "R1");
    cyc(1, 1, 2, 3, 1,0,0,0,0,     1,0,0,0,0,0, "R1");
    cyc(1, 3, 7, 4, 1,0,0,0,0,     1,0,0,0,1,0, "R4");
    cyc(1, 3, 4, 5, 1,0,0,0,0,     1,0,0,0,2,1, "R5");
    cyc(1, 3, 0, 6, 1,0,0,0,0,     1,0,0,0,0,0, "R6");
    cyc(1, 1, 0, 8, 1,1,0,0,0,     1,0,0,0,0,0, "R5");
    cyc(1, 8, 2, 9, 1,0,0,0,0,     0,1,1,0,0,0, "R2");
    cyc(1, 8, 2, 9, 1,0,0,0,0,     1,0,0,0,2,0, "R5");
    cyc(1, 1, 1, 9, 1,0,0,0,0,     1,0,0,0,0,0, "R3");
    cyc(1, 9, 0,10, 1,0,0,0,0,     1,0,0,0,1,0, "R11");
    cyc(1, 9,10,11, 1,0,0,0,0,     1,0,0,0,2,1, "R8");
    cyc(1,11, 2, 1, 1,0,0,0,0,     1,0,0,0,1,0, "R3");
    cyc(1, 0, 0,11, 1,0,0,0,0,     1,0,0,0,0,0, "R7");
    cyc(1,11, 1,12, 1,0,0,0,0,     1,0,0,0,1,2, "R7");
    cyc(1, 0, 0,13, 1,1,0,0,0,     1,0,0,0,0,0, "R5");
    cyc(1, 0,13,14, 1,0,0,0,0,     0,1,1,0,0,0, "R2");
    cyc(1, 0,13,14, 1,0,0,0,0,     1,0,0,0,0,2, "R5");
    cyc(1, 1, 1, 0, 1,0,0,0,0,     1,0,0,0,0,0, "R6");
    cyc(1, 0, 0,15, 1,0,0,0,0,     1,0,0,0,0,0, "R6");
    cyc(1, 1, 2, 0, 0,0,1,0,0,     1,0,1,0,0,0, "R9");
    cyc(0, 0, 0, 0, 0,0,0,1,0,     0,0,1,0,0,0, "R9");
    cyc(0, 0, 0, 0, 0,0,0,0,0,     0,0,0,0,0,0, "R9");
    cyc(1, 0, 0, 0, 0,0,1,0,0,     1,0,1,0,0,0, "R9");
    cyc(0, 0, 0, 0, 0,0,0,0,0,     0,0,1,0,0,0, "R9");
    cyc(0, 0, 0, 0, 0,0,0,1,1,     0,0,1,1,0,0, "R10");
    cyc(0, 0, 0, 0, 0,0,0,1,1,     0,0,0,0,0,0, "R10");
    cyc(1, 0, 0,16, 1,1,0,0,0,     1,0,0,0,0,0, "R5");
    cyc(1,16, 0, 0, 0,0,1,0,0,     0,1,1,0,0,0, "R2");
    cyc(1,16, 0, 0, 0,0,1,0,0,     1,0,1,0,2,0, "R9");
    cyc(0, 0, 0, 0, 0,0,0,1,0,     0,0,1,0,0,0, "R9");
    cyc(0, 0, 0, 0, 0,0,0,0,0,     0,0,0,0,0,0, "R9");
    repeat (2) @(negedge clk);
    #5;
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule